// File: doc/BRIEF.md
# Static Memory Bus Cycle Sequencer

This block turns single requests into read and write cycles on an asynchronous static memory bus that has up to four chip selects. A request carries a chip-select index, an address, a write byte and a direction flag. It is offered on a valid/ready handshake and is taken on any clock edge where both are high. Back-pressure is simple. `req_ready` is high only while the sequencer is idle or in the final cycle of an access. A requester holding `req_valid` high therefore gets its next access placed directly behind the current one. Read results come back on `rd_valid`/`rd_data` for one cycle, with no back-pressure. The consumer must take the byte in the cycle it is shown.

Each chip select has its own setup, strobe pulse and total cycle length, supplied as plain input ports. The lengths count clock cycles from the cycle in which the address first becomes valid. The chip-select line is low for the whole access. The read or write strobe is low for the pulse window that follows the setup cycles. The remaining cycles are hold. When a new access follows another one directly but targets a different chip select, one dead cycle is placed between them. In that cycle every control line is high. A chip select can be set so that writes are ended by the write strobe. In that setting the address and the chip select stay valid for at least one cycle after the write strobe rises, even if no hold is programmed.

Top module: `sram_cycle_seq`

## Requirements
- R1: After reset every chip-select line, `mem_nrd` and `mem_nwe` are high, `mem_doe` and `rd_valid` are low, and `req_ready` is high.
- R2: For an accepted request, the chip-select line for `req_cs` (bit index equals the index value) goes low in the next cycle. `mem_addr` shows the request address for that whole access. The strobe (`mem_nrd` for reads, `mem_nwe` for writes) is low in access cycles setup through setup+pulse-1, counted from 0.
- R3: An access lasts max(cycle, setup+pulse+h) cycles, where h is 1 for a write on a chip select in write-strobe-ended mode and 0 otherwise. Cycles after the strobe window are hold.
- R4: When a request is accepted in the last cycle of an access and targets a different chip select, exactly one cycle with all control lines high precedes the new access. The chip-select lines never switch from one low line to another without it.
- R5: A request accepted in the last cycle of an access to the same chip select starts in the very next cycle, with no dead cycle.
- R6: A programmed pulse of zero sets that chip select's bit of `cfg_err`, and the strobe is then low for exactly one cycle.
- R7: With `cfg_nwe_mode` set for a chip select (1 = write ended by the strobe) and cycle ≤ setup+pulse, the address and chip select stay valid for one cycle after `mem_nwe` rises. With the mode bit clear, no such cycle is added.
- R8: On a read, `mem_din` is sampled on the clock edge at which `mem_nrd` rises. The byte appears on `rd_data` with `rd_valid` high for one cycle right after that edge.
- R9: On a write, `mem_doe` is high and `mem_dout` carries the write byte for every cycle in which the chip select is low. On a read, `mem_doe` stays low.
- R10: `req_ready` is low during an access except in its last cycle, and low during a dead cycle.
- R11: At most one chip-select line is low at a time. `mem_nrd` and `mem_nwe` are never low together, and neither is low while all chip selects are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request can be taken this cycle |
| req_cs | input | 2 | Target chip-select index |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 16 | Access address |
| req_wdata | input | 8 | Write byte |
| rd_valid | output | 1 | Read byte valid (one cycle) |
| rd_data | output | 8 | Captured read byte |
| cfg_setup | input | 24 | Setup cycles, 6 bits per chip select (select n at bits 6n+5:6n) |
| cfg_pulse | input | 24 | Strobe pulse cycles, same packing |
| cfg_cycle | input | 24 | Total cycle length, same packing |
| cfg_nwe_mode | input | 4 | Per chip select: 1 = writes ended by the write strobe |
| cfg_err | output | 4 | Per chip select: pulse programmed as zero |
| mem_addr | output | 16 | Memory address bus |
| mem_dout | output | 8 | Memory data out |
| mem_doe | output | 1 | Data-out enable |
| mem_din | input | 8 | Memory data in |
| mem_ncs | output | 4 | Active-low chip selects |
| mem_nrd | output | 1 | Active-low read strobe |
| mem_nwe | output | 1 | Active-low write strobe |

## Verification
The assertions assume that the timing ports for a chip select stay constant while an access to it is in progress, and that `mem_din` is driven to a known value. The bench therefore changes timing only between scenarios, while the bus is idle. It drives `mem_din` at each falling edge with a value tied to the cycle index, so the capture edge of a read is visible in the returned byte. Requests are offered only at falling edges and are held until taken. Back-to-back cases keep `req_valid` high so that the second request lands in the last cycle of the first access.

// File: rtl/scs_pkg.sv
package scs_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_GAP  = 2'd1,
    ST_ACC  = 2'd2
  } seq_state_t;
endpackage

// File: rtl/scs_timing_sel.sv
module scs_timing_sel #(
  parameter int NCS = 4,
  parameter int TW  = 6,
  localparam int CSW = (NCS > 1) ? $clog2(NCS) : 1,
  localparam int CW  = TW + 2
) (
  input  logic [NCS*TW-1:0] cfg_setup,
  input  logic [NCS*TW-1:0] cfg_pulse,
  input  logic [NCS*TW-1:0] cfg_cycle,
  input  logic [NCS-1:0]    cfg_nwe_mode,
  input  logic [CSW-1:0]    sel_cs,
  input  logic              sel_write,
  output logic [TW-1:0]     setup_o,
  output logic [TW:0]       strobe_end,
  output logic [CW-1:0]     last_cnt,
  output logic [NCS-1:0]    cfg_err
);
  logic [TW-1:0] setup_a [NCS];
  logic [TW-1:0] pulse_a [NCS];
  logic [TW-1:0] cycle_a [NCS];

  for (genvar g = 0; g < NCS; g++) begin : g_cs
    logic [TW-1:0] raw_pulse;
    assign raw_pulse  = cfg_pulse[g*TW +: TW];
    assign setup_a[g] = cfg_setup[g*TW +: TW];
    assign cycle_a[g] = cfg_cycle[g*TW +: TW];
    // zero pulse is illegal: flag and clamp to one cycle
    assign cfg_err[g] = (raw_pulse == '0);
    assign pulse_a[g] = (raw_pulse == '0) ? TW'(1) : raw_pulse;
  end

  logic          hold_min;
  logic [CW-1:0] min_total;
  logic [CW-1:0] cyc_len;
  logic [CW-1:0] total;

  always_comb begin
    setup_o    = setup_a[sel_cs];
    strobe_end = {1'b0, setup_o} + {1'b0, pulse_a[sel_cs]};
    hold_min   = sel_write & cfg_nwe_mode[sel_cs];
    min_total  = {1'b0, strobe_end} + CW'(hold_min);
    cyc_len    = CW'(cycle_a[sel_cs]);
    total      = (cyc_len > min_total) ? cyc_len : min_total;
    last_cnt   = total - CW'(1);
  end
endmodule

// File: rtl/scs_strobe_dec.sv
module scs_strobe_dec #(
  parameter int NCS = 4,
  parameter int TW  = 6,
  localparam int CSW = (NCS > 1) ? $clog2(NCS) : 1,
  localparam int CW  = TW + 2
) (
  input  logic           active,
  input  logic [CW-1:0]  cnt,
  input  logic [TW-1:0]  setup,
  input  logic [TW:0]    strobe_end,
  input  logic [CSW-1:0] cs,
  input  logic           write,
  output logic [NCS-1:0] ncs,
  output logic           nrd,
  output logic           nwe,
  output logic           doe
);
  logic strobe_on;

  assign strobe_on = active && (cnt >= CW'(setup)) && (cnt < CW'(strobe_end));

  for (genvar g = 0; g < NCS; g++) begin : g_ncs
    assign ncs[g] = !(active && (cs == CSW'(g)));
  end

  assign nrd = !(strobe_on && !write);
  assign nwe = !(strobe_on && write);
  assign doe = active && write;
endmodule

// File: rtl/sram_cycle_seq.sv
module sram_cycle_seq #(
  parameter int NCS = 4,
  parameter int AW  = 16,
  parameter int DW  = 8,
  parameter int TW  = 6,
  localparam int CSW = (NCS > 1) ? $clog2(NCS) : 1,
  localparam int CW  = TW + 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [CSW-1:0]    req_cs,
  input  logic              req_write,
  input  logic [AW-1:0]     req_addr,
  input  logic [DW-1:0]     req_wdata,
  output logic              rd_valid,
  output logic [DW-1:0]     rd_data,
  input  logic [NCS*TW-1:0] cfg_setup,
  input  logic [NCS*TW-1:0] cfg_pulse,
  input  logic [NCS*TW-1:0] cfg_cycle,
  input  logic [NCS-1:0]    cfg_nwe_mode,
  output logic [NCS-1:0]    cfg_err,
  output logic [AW-1:0]     mem_addr,
  output logic [DW-1:0]     mem_dout,
  output logic              mem_doe,
  input  logic [DW-1:0]     mem_din,
  output logic [NCS-1:0]    mem_ncs,
  output logic              mem_nrd,
  output logic              mem_nwe
);
  import scs_pkg::*;

  seq_state_t     state;
  logic [CW-1:0]  cnt;
  logic [CSW-1:0] cur_cs;
  logic           cur_write;
  logic [AW-1:0]  cur_addr;
  logic [DW-1:0]  cur_wdata;

  logic [TW-1:0]  setup_sel;
  logic [TW:0]    strobe_end;
  logic [CW-1:0]  last_cnt;
  logic           last_acc;
  logic           accept;
  logic           nrd_rise;

  scs_timing_sel #(.NCS(NCS), .TW(TW)) u_tsel (
    .cfg_setup    (cfg_setup),
    .cfg_pulse    (cfg_pulse),
    .cfg_cycle    (cfg_cycle),
    .cfg_nwe_mode (cfg_nwe_mode),
    .sel_cs       (cur_cs),
    .sel_write    (cur_write),
    .setup_o      (setup_sel),
    .strobe_end   (strobe_end),
    .last_cnt     (last_cnt),
    .cfg_err      (cfg_err)
  );

  scs_strobe_dec #(.NCS(NCS), .TW(TW)) u_dec (
    .active     (state == ST_ACC),
    .cnt        (cnt),
    .setup      (setup_sel),
    .strobe_end (strobe_end),
    .cs         (cur_cs),
    .write      (cur_write),
    .ncs        (mem_ncs),
    .nrd        (mem_nrd),
    .nwe        (mem_nwe),
    .doe        (mem_doe)
  );

  assign last_acc  = (state == ST_ACC) && (cnt == last_cnt);
  assign req_ready = (state == ST_IDLE) || last_acc;
  assign accept    = req_valid && req_ready;
  // final strobe cycle of a read: the next edge raises the read strobe
  assign nrd_rise  = (state == ST_ACC) && !cur_write &&
                     ((cnt + CW'(1)) == CW'(strobe_end));

  assign mem_addr = cur_addr;
  assign mem_dout = cur_wdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      cnt   <= '0;
    end else begin
      unique case (state)
        ST_IDLE: if (accept) begin
          state <= ST_ACC;
          cnt   <= '0;
        end
        ST_ACC: begin
          if (last_acc) begin
            cnt <= '0;
            if (!accept)             state <= ST_IDLE;
            else if (req_cs != cur_cs) state <= ST_GAP;
            else                     state <= ST_ACC;
          end else begin
            cnt <= cnt + CW'(1);
          end
        end
        ST_GAP: begin
          state <= ST_ACC;
          cnt   <= '0;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_cs    <= '0;
      cur_write <= 1'b0;
      cur_addr  <= '0;
      cur_wdata <= '0;
    end else if (accept) begin
      cur_cs    <= req_cs;
      cur_write <= req_write;
      cur_addr  <= req_addr;
      cur_wdata <= req_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= nrd_rise;
      if (nrd_rise) rd_data <= mem_din;
    end
  end
endmodule

// File: rtl/scs_checker.sv
module scs_checker #(
  parameter int NCS = 4
) (
  input logic           clk,
  input logic           rst_n,
  input logic [NCS-1:0] mem_ncs,
  input logic           mem_nrd,
  input logic           mem_nwe,
  input logic           mem_doe,
  input logic           rd_valid,
  input logic           req_ready
);
  localparam logic [NCS-1:0] ALL_HI = {NCS{1'b1}};

  p_one_cs_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~mem_ncs));

  p_strobe_excl_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !(!mem_nrd && !mem_nwe));

  p_strobe_in_cs_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_nrd || !mem_nwe) |-> (mem_ncs != ALL_HI));

  p_doe_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
    mem_doe |-> ((mem_ncs != ALL_HI) && mem_nrd));

  p_no_cs_switch_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (($past(mem_ncs) != ALL_HI) && (mem_ncs != ALL_HI)) |-> (mem_ncs == $past(mem_ncs)));

  p_gap_one_cycle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!req_ready && (mem_ncs == ALL_HI)) |=> (mem_ncs != ALL_HI));

  p_rd_after_nrd_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> ($past(mem_nrd) == 1'b0));
endmodule

bind sram_cycle_seq scs_checker #(.NCS(NCS)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .mem_ncs   (mem_ncs),
  .mem_nrd   (mem_nrd),
  .mem_nwe   (mem_nwe),
  .mem_doe   (mem_doe),
  .rd_valid  (rd_valid),
  .req_ready (req_ready)
);

// File: tb/sram_cycle_seq_test.sv
`timescale 1ns/1ps
module sram_cycle_seq_test;
  localparam int NCS = 4;
  localparam int AW  = 16;
  localparam int DW  = 8;
  localparam int TW  = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic              req_valid = 1'b0;
  logic              req_ready;
  logic [1:0]        req_cs = '0;
  logic              req_write = 1'b0;
  logic [AW-1:0]     req_addr = '0;
  logic [DW-1:0]     req_wdata = '0;
  logic              rd_valid;
  logic [DW-1:0]     rd_data;
  logic [NCS*TW-1:0] cfg_setup, cfg_pulse, cfg_cycle;
  logic [NCS-1:0]    cfg_nwe_mode = '0;
  logic [NCS-1:0]    cfg_err;
  logic [AW-1:0]     mem_addr;
  logic [DW-1:0]     mem_dout;
  logic              mem_doe;
  logic [DW-1:0]     mem_din = '0;
  logic [NCS-1:0]    mem_ncs;
  logic              mem_nrd, mem_nwe;

  int b_setup [NCS];
  int b_pulse [NCS];
  int b_cycle [NCS];

  always_comb begin
    for (int i = 0; i < NCS; i++) begin
      cfg_setup[i*TW +: TW] = TW'(b_setup[i]);
      cfg_pulse[i*TW +: TW] = TW'(b_pulse[i]);
      cfg_cycle[i*TW +: TW] = TW'(b_cycle[i]);
    end
  end

  sram_cycle_seq #(.NCS(NCS), .AW(AW), .DW(DW), .TW(TW)) uut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_cs(req_cs),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rd_valid(rd_valid), .rd_data(rd_data),
    .cfg_setup(cfg_setup), .cfg_pulse(cfg_pulse), .cfg_cycle(cfg_cycle),
    .cfg_nwe_mode(cfg_nwe_mode), .cfg_err(cfg_err),
    .mem_addr(mem_addr), .mem_dout(mem_dout), .mem_doe(mem_doe),
    .mem_din(mem_din), .mem_ncs(mem_ncs), .mem_nrd(mem_nrd), .mem_nwe(mem_nwe)
  );

  int n_checks = 0;
  int n_fails  = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic int pe(input int cs);
    return (b_pulse[cs] == 0) ? 1 : b_pulse[cs];
  endfunction

  function automatic int tot(input int cs, input bit wr);
    int m;
    m = b_setup[cs] + pe(cs) + ((wr && cfg_nwe_mode[cs]) ? 1 : 0);
    return (b_cycle[cs] > m) ? b_cycle[cs] : m;
  endfunction

  // Issue access A (and optionally B back to back) and compare the bus trace.
  task automatic run_seq(input int a_cs, input bit a_wr, input logic [15:0] a_ad,
                         input logic [7:0] a_wd, input bit two, input int b_cs,
                         input bit b_wr, input logic [15:0] b_ad, input logic [7:0] b_wd,
                         input string req);
    int ta, tb, gi, sb, cs, off;
    bit acc, wr, pend, bdone;
    bit bad_ctl, bad_rdy, bad_dat;
    logic [3:0] e_ncs; logic e_nrd, e_nwe, e_doe, e_rdy, e_rv;
    logic [15:0] ad; logic [7:0] wd, e_rd;
    ta = tot(a_cs, a_wr);
    tb = two ? tot(b_cs, b_wr) : 0;
    gi = (two && a_cs != b_cs) ? 1 : 0;
    sb = ta + gi;
    bad_ctl = 0; bad_rdy = 0; bad_dat = 0;
    @(negedge clk);
    req_cs = 2'(a_cs); req_write = a_wr; req_addr = a_ad; req_wdata = a_wd;
    req_valid = 1'b1;
    while (!req_ready) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    bdone = !two;
    if (two) begin
      req_cs = 2'(b_cs); req_write = b_wr; req_addr = b_ad; req_wdata = b_wd;
    end else req_valid = 1'b0;
    for (int idx = 0; idx < 48; idx++) begin
      mem_din = 8'h40 + 8'(idx);
      #0.1;
      acc = 0; cs = 0; off = 0; wr = 0; ad = '0; wd = '0;
      if (idx < ta) begin
        acc = 1; cs = a_cs; off = idx; wr = a_wr; ad = a_ad; wd = a_wd;
      end else if (two && idx >= sb && idx < sb + tb) begin
        acc = 1; cs = b_cs; off = idx - sb; wr = b_wr; ad = b_ad; wd = b_wd;
      end
      e_ncs = acc ? ~(4'b1 << cs) : 4'hF;
      e_nrd = !(acc && !wr && off >= b_setup[cs] && off < b_setup[cs] + pe(cs));
      e_nwe = !(acc && wr && off >= b_setup[cs] && off < b_setup[cs] + pe(cs));
      e_doe = acc && wr;
      e_rdy = acc ? (off == tot(cs, wr) - 1) : !(gi == 1 && idx == ta);
      e_rv = 0; e_rd = '0;
      if (!a_wr && idx == b_setup[a_cs] + pe(a_cs)) begin
        e_rv = 1; e_rd = 8'h40 + 8'(idx - 1);
      end
      if (two && !b_wr && idx == sb + b_setup[b_cs] + pe(b_cs)) begin
        e_rv = 1; e_rd = 8'h40 + 8'(idx - 1);
      end
      if (!bad_ctl && ({mem_ncs, mem_nrd, mem_nwe, mem_doe} != {e_ncs, e_nrd, e_nwe, e_doe})) begin
        bad_ctl = 1;
        $display("FAIL %s control at cycle %0d: actual %0h expected %0h", req, idx,
                 {mem_ncs, mem_nrd, mem_nwe, mem_doe}, {e_ncs, e_nrd, e_nwe, e_doe});
      end
      if (!bad_rdy && (req_ready !== e_rdy)) begin
        bad_rdy = 1;
        $display("FAIL %s R10 ready at cycle %0d: actual %0h expected %0h", req, idx, req_ready, e_rdy);
      end
      if (!bad_dat && ((rd_valid !== e_rv) || (e_rv && rd_data !== e_rd) ||
                       (acc && mem_addr !== ad) || (acc && wr && mem_dout !== wd))) begin
        bad_dat = 1;
        $display("FAIL %s data at cycle %0d: actual rv=%0h rd=%0h addr=%0h dout=%0h expected rv=%0h rd=%0h addr=%0h dout=%0h",
                 req, idx, rd_valid, rd_data, mem_addr, mem_dout, e_rv, e_rd, ad, wd);
      end
      pend = !bdone && req_ready;
      @(negedge clk);
      if (pend) begin
        req_valid = 1'b0; bdone = 1;
      end
    end
    n_checks += 3;
    n_fails  += int'(bad_ctl) + int'(bad_rdy) + int'(bad_dat);
  endtask

  task automatic t_reset;
    #0.1;
    check(mem_ncs == 4'hF && mem_nrd && mem_nwe && !mem_doe && !rd_valid && req_ready,
          "R1", "reset state", {mem_ncs, mem_nrd, mem_nwe, mem_doe, rd_valid, req_ready},
          {4'hF, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1});
  endtask

  task automatic t_read_basic;   // R2 R8 R9: read, setup 1, pulse 2, cycle 5
    run_seq(0, 0, 16'h1234, 8'h00, 0, 0, 0, 16'h0, 8'h0, "R2/R8");
  endtask

  task automatic t_write_ncs_mode;  // R9 R7: cycle == setup+pulse, no extension
    run_seq(1, 1, 16'hBEEF, 8'hA5, 0, 0, 0, 16'h0, 8'h0, "R9/R7");
  endtask

  task automatic t_write_nwe_mode;  // R7: one extra hold cycle
    run_seq(2, 1, 16'h0F0F, 8'h3C, 0, 0, 0, 16'h0, 8'h0, "R7");
  endtask

  task automatic t_short_cycle;     // R3: cycle shorter than setup+pulse
    run_seq(3, 0, 16'h5555, 8'h00, 0, 0, 0, 16'h0, 8'h0, "R3");
  endtask

  task automatic t_same_cs;         // R5
    run_seq(0, 0, 16'h0100, 8'h00, 1, 0, 1, 16'h0101, 8'h77, "R5");
  endtask

  task automatic t_diff_cs;         // R4
    run_seq(0, 1, 16'h0200, 8'h11, 1, 1, 0, 16'h0201, 8'h00, "R4");
    run_seq(2, 1, 16'h0300, 8'h22, 1, 3, 1, 16'h0301, 8'h33, "R4/R11");
  endtask

  task automatic t_zero_pulse;      // R6
    b_pulse[3] = 0; b_setup[3] = 1; b_cycle[3] = 2;
    #1;
    check(cfg_err == 4'b1000, "R6", "cfg_err", 32'(cfg_err), 32'h8);
    run_seq(3, 0, 16'h7777, 8'h00, 0, 0, 0, 16'h0, 8'h0, "R6");
    b_pulse[3] = 3;
    #1;
    check(cfg_err == 4'b0000, "R6", "cfg_err cleared", 32'(cfg_err), 32'h0);
  endtask

  initial begin
    b_setup[0] = 1; b_pulse[0] = 2; b_cycle[0] = 5;
    b_setup[1] = 0; b_pulse[1] = 3; b_cycle[1] = 3;
    b_setup[2] = 1; b_pulse[2] = 2; b_cycle[2] = 3;
    b_setup[3] = 2; b_pulse[3] = 3; b_cycle[3] = 2;
    cfg_nwe_mode = 4'b0100;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_read_basic();
    t_write_ncs_mode();
    t_write_nwe_mode();
    t_short_cycle();
    t_same_cs();
    t_diff_cs();
    t_zero_pulse();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_checks++; n_fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    $finish;
  end
endmodule